// File: doc/BRIEF.md
# J1850 Frame Error Monitor

This block sits beside a J1850 link controller and watches every frame that passes over the wire, whether the local node is receiving it or driving it. It consumes a stream of symbols that a timing-recovery stage has already decoded. For each symbol slot it also sees the symbol the local transmitter meant to place on the bus, and a flag that says whether the transmitter is active. It follows the bit position inside each byte and runs a CRC-8 over received data. It sorts what goes wrong into symbol, transmission and CRC errors, and it applies the recovery that each error calls for.

The symbol input is a valid/ready stream. The monitor never applies back-pressure: `sym_ready` is tied high, and a symbol is consumed on every clock edge where `sym_valid` is high. While `sym_valid` is low nothing advances. The transmit side is controlled through plain pins. `tx_go` grants the start of a frame, `tx_abort` stops the transmitter in the cycle the fault is seen, and the data-empty condition paces byte loads. Software sees a single encoded status code that names the most urgent pending condition. `irq` follows that code when interrupts are enabled.

Top module: `j1850_err_monitor`

## Requirements
- R1: An EOD (code 3) or EOF (code 4) symbol received in a frame when the bit position is not a multiple of 8 sets the symbol-error status (code 4). The monitor then ignores symbols until it receives IDLE (code 7) or EOF.
- R2: While the transmitter is active and its intended symbol is EOD, receiving an active symbol (BIT0, code 0, or SOF, code 2) sets symbol-error status and raises `tx_abort` in that same cycle.
- R3: While the transmitter is active, an intended INV symbol (code 6), or an intended EOD/EOF off a byte boundary, raises `tx_abort` in that same cycle and sets transmission-error status (code 3).
- R4: An INV symbol, or a second SOF, received inside a frame sets symbol-error status.
- R5: The CRC is CRC-8 with polynomial 0x1D and initial value 0xFF, fed MSB first, and the transmitted check byte is the complement of the result. At an EOD on a byte boundary, data plus check byte must leave the residue 0xC4. Otherwise CRC-error status is set (code 2).
- R6: A BREAK (code 5) seen inside a frame or during transmit sets symbol-error status and aborts any transmission. A status read clears it. After a BREAK, symbols are ignored until IDLE/EOF, and only then does an SOF open a frame.
- R7: If the transmitter drives SOF and the bus does not return SOF, the monitor sets transmission-error status and raises `tx_abort`. It then holds `tx_go` low until `tx_req` has been dropped and raised again.
- R8: `tx_go` stays low while `bus_active` is high, and it returns as soon as the bus is passive and `tx_req` is high while waiting for a frame.
- R9: Frames of any length are accepted. The byte count saturates instead of wrapping, and only an EOD arriving with zero bytes counted since the frame start or the last EOD is a framing error (symbol-error status).
- R10: The data-empty condition (code 1) is raised when a transmitted SOF is echoed and after every eighth transmitted bit. `tx_load` clears it, and a load wins over a set in the same cycle.
- R11: `stat_code` reports only the highest pending condition, in the order symbol error 4, transmission error 3, CRC error 2, data-empty 1, none 0. `stat_rd` clears the condition currently reported, except data-empty, and a new event in the same cycle wins over the clear.
- R12: `irq` is high exactly when `irq_en` is high and `stat_code` is not 0.
- R13: `sym_ready` is always high. A cycle with `sym_valid` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Symbol stream valid |
| sym_ready | output | 1 | Symbol stream ready, always 1 |
| rx_sym | input | 3 | Symbol sensed on the bus |
| tx_active | input | 1 | Local transmitter drives this slot |
| tx_sym | input | 3 | Symbol the transmitter intends for this slot |
| tx_req | input | 1 | Transmit command from the host |
| bus_active | input | 1 | Bus currently at the active level |
| tx_load | input | 1 | Host loaded the next transmit byte |
| stat_rd | input | 1 | Host reads the status code |
| irq_en | input | 1 | Interrupt enable |
| tx_go | output | 1 | Grant to start a frame |
| tx_abort | output | 1 | Stop the transmitter now |
| stat_code | output | 3 | Highest-priority pending condition |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the monitor with `BYTE_CNT_W` set to 3, so the byte counter reaches its ceiling within an eight-byte frame. A counter that wrapped would read zero at the EOD and raise a false framing error, which the bench would catch. The CRC parameters keep their default values, so check bytes computed in the bench exercise the real 0xC4 residue on good and corrupted frames. A vector table steps through the transmit-fault, priority and recovery sequences, and directed frames cover CRC, long frames, data-empty pacing and reset.

// File: rtl/j1850_mon_pkg.sv
package j1850_mon_pkg;

  typedef enum logic [2:0] {
    SYM_B0   = 3'd0,
    SYM_B1   = 3'd1,
    SYM_SOF  = 3'd2,
    SYM_EOD  = 3'd3,
    SYM_EOF  = 3'd4,
    SYM_BRK  = 3'd5,
    SYM_INV  = 3'd6,
    SYM_IDLE = 3'd7
  } sym_e;

  typedef enum logic [1:0] {
    TRK_WAIT_SOF  = 2'd0,
    TRK_FRAME     = 2'd1,
    TRK_WAIT_IDLE = 2'd2
  } trk_e;

  typedef enum logic [2:0] {
    ST_NONE   = 3'd0,
    ST_TDRE   = 3'd1,
    ST_CRC    = 3'd2,
    ST_TXERR  = 3'd3,
    ST_SYMERR = 3'd4
  } stat_e;

  function automatic logic is_data(sym_e s);
    return (s == SYM_B0) || (s == SYM_B1);
  endfunction

endpackage

// File: rtl/j1850_sym_tracker.sv
module j1850_sym_tracker
  import j1850_mon_pkg::*;
#(
  parameter int BYTE_BITS  = 8,
  parameter int BYTE_CNT_W = 16,
  localparam int BIT_W     = $clog2(BYTE_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  sym_e             rx_s,
  input  logic             tx_active,
  output trk_e             state,
  output logic [BIT_W-1:0] bit_idx,
  output logic             byte_done,
  output logic             sym_err_ev,
  output logic             crc_chk,
  output logic             crc_bit_en,
  output logic             crc_init
);

  localparam logic [BIT_W-1:0]      BIT_LAST = BIT_W'(BYTE_BITS - 1);
  localparam logic [BIT_W-1:0]      BIT_ONE  = BIT_W'(1);
  localparam logic [BYTE_CNT_W-1:0] BYTE_MAX = '1;
  localparam logic [BYTE_CNT_W-1:0] BYTE_ONE = BYTE_CNT_W'(1);

  logic [BYTE_CNT_W-1:0] bytes;
  logic in_frame, boundary, eod_ev, eof_ev, brk_ev, inv_ev, frm_ev;

  always_comb begin
    in_frame   = (state == TRK_FRAME);
    boundary   = (bit_idx == '0);
    eod_ev     = beat && in_frame && (rx_s == SYM_EOD);
    eof_ev     = beat && in_frame && (rx_s == SYM_EOF);
    brk_ev     = beat && (rx_s == SYM_BRK) && (in_frame || tx_active);
    inv_ev     = beat && in_frame && ((rx_s == SYM_INV) || (rx_s == SYM_SOF));
    frm_ev     = (eod_ev && (!boundary || (bytes == '0))) || (eof_ev && !boundary);
    sym_err_ev = brk_ev || inv_ev || frm_ev;
    crc_chk    = eod_ev && boundary && (bytes != '0);
    crc_bit_en = beat && in_frame && is_data(rx_s);
    byte_done  = crc_bit_en && (bit_idx == BIT_LAST);
    crc_init   = (beat && (state == TRK_WAIT_SOF) && (rx_s == SYM_SOF)) || crc_chk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TRK_WAIT_SOF;
      bit_idx <= '0;
      bytes   <= '0;
    end else if (sym_err_ev) begin
      state <= TRK_WAIT_IDLE;
    end else begin
      unique case (state)
        TRK_WAIT_SOF: begin
          if (beat && (rx_s == SYM_SOF)) begin
            state   <= TRK_FRAME;
            bit_idx <= '0;
            bytes   <= '0;
          end
        end
        TRK_FRAME: begin
          if (crc_bit_en) begin
            bit_idx <= byte_done ? '0 : bit_idx + BIT_ONE;
            if (byte_done && (bytes != BYTE_MAX)) bytes <= bytes + BYTE_ONE;
          end
          if (crc_chk) bytes <= '0;
          if (beat && ((rx_s == SYM_EOF) || (rx_s == SYM_IDLE))) state <= TRK_WAIT_SOF;
        end
        TRK_WAIT_IDLE: begin
          if (beat && ((rx_s == SYM_IDLE) || (rx_s == SYM_EOF))) state <= TRK_WAIT_SOF;
        end
        default: state <= TRK_WAIT_IDLE;
      endcase
    end
  end

  // R1: an end symbol off a byte boundary forces the wait-for-idle state
  a_r1_offbound_waits_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_frame && ((rx_s == SYM_EOD) || (rx_s == SYM_EOF)) && !boundary)
    |=> (state == TRK_WAIT_IDLE));

  // R9: a full byte at the ceiling leaves the count at the ceiling
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (bytes == BYTE_MAX)) |=> (bytes == BYTE_MAX));

  // R6: while waiting for idle, any symbol other than IDLE/EOF keeps the wait
  a_r6_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TRK_WAIT_IDLE) && !(beat && ((rx_s == SYM_IDLE) || (rx_s == SYM_EOF))))
    |=> (state == TRK_WAIT_IDLE));

endmodule

// File: rtl/j1850_crc8.sv
module j1850_crc8 #(
  parameter int              CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h1D,
  parameter logic [CRC_W-1:0] INIT = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             bit_en,
  input  logic             bit_val,
  output logic [CRC_W-1:0] crc
);

  logic             fb;
  logic [CRC_W-1:0] nxt;

  always_comb begin
    fb  = crc[CRC_W-1] ^ bit_val;
    nxt = {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= INIT;
    else if (init)   crc <= INIT;
    else if (bit_en) crc <= nxt;
  end

endmodule

// File: rtl/j1850_tx_guard.sv
module j1850_tx_guard
  import j1850_mon_pkg::*;
#(
  parameter int BIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             tx_active,
  input  sym_e             rx_s,
  input  sym_e             tx_s,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             line_idle,
  input  logic             byte_done,
  input  logic             tx_req,
  input  logic             bus_active,
  input  logic             tx_load,
  output logic             tx_go,
  output logic             tx_abort,
  output logic             tx_err_ev,
  output logic             clash_ev,
  output logic             tdre
);

  logic tx_beat, sof_ok, hold, tdre_set;

  always_comb begin
    tx_beat   = beat && tx_active;
    sof_ok    = tx_beat && (tx_s == SYM_SOF) && (rx_s == SYM_SOF);
    tx_err_ev = tx_beat && ((tx_s == SYM_INV)
              || (((tx_s == SYM_EOD) || (tx_s == SYM_EOF)) && (bit_idx != '0))
              || ((tx_s == SYM_SOF) && (rx_s != SYM_SOF)));
    clash_ev  = tx_beat && (tx_s == SYM_EOD) && ((rx_s == SYM_B0) || (rx_s == SYM_SOF));
    tx_abort  = tx_err_ev || clash_ev || (tx_beat && (rx_s == SYM_BRK));
    tx_go     = tx_req && !bus_active && line_idle && !hold;
    tdre_set  = sof_ok || (tx_active && byte_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
      tdre <= 1'b0;
    end else begin
      if (tx_abort)     hold <= 1'b1;
      else if (!tx_req) hold <= 1'b0;
      if (tx_load)       tdre <= 1'b0;
      else if (tdre_set) tdre <= 1'b1;
    end
  end

  // R7: no grant right after an abort while the same command is still up
  a_r7_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_abort) && tx_req) |-> !tx_go);

  // R10: a load empties nothing but clears the data-empty condition
  a_r10_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tdre);

endmodule

// File: rtl/j1850_status.sv
module j1850_status
  import j1850_mon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sym_ev,
  input  logic  tx_ev,
  input  logic  crc_ev,
  input  logic  tdre,
  input  logic  stat_rd,
  input  logic  irq_en,
  output stat_e code,
  output logic  irq
);

  logic f_sym, f_tx, f_crc;

  always_comb begin
    if (f_sym)      code = ST_SYMERR;
    else if (f_tx)  code = ST_TXERR;
    else if (f_crc) code = ST_CRC;
    else if (tdre)  code = ST_TDRE;
    else            code = ST_NONE;
    irq = irq_en && (code != ST_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_sym <= 1'b0;
      f_tx  <= 1'b0;
      f_crc <= 1'b0;
    end else begin
      f_sym <= sym_ev || (f_sym && !(stat_rd && (code == ST_SYMERR)));
      f_tx  <= tx_ev  || (f_tx  && !(stat_rd && (code == ST_TXERR)));
      f_crc <= crc_ev || (f_crc && !(stat_rd && (code == ST_CRC)));
    end
  end

  // R11: reading the top symbol error with no new one retires it
  a_r11_rd_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (code == ST_SYMERR) && !sym_ev) |=> (code != ST_SYMERR));

endmodule

// File: rtl/j1850_err_monitor.sv
module j1850_err_monitor
  import j1850_mon_pkg::*;
#(
  parameter int         BYTE_BITS   = 8,
  parameter int         BYTE_CNT_W  = 16,
  parameter logic [7:0] CRC_POLY    = 8'h1D,
  parameter logic [7:0] CRC_INIT    = 8'hFF,
  parameter logic [7:0] CRC_RESIDUE = 8'hC4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  output logic       sym_ready,
  input  logic [2:0] rx_sym,
  input  logic       tx_active,
  input  logic [2:0] tx_sym,
  input  logic       tx_req,
  input  logic       bus_active,
  input  logic       tx_load,
  input  logic       stat_rd,
  input  logic       irq_en,
  output logic       tx_go,
  output logic       tx_abort,
  output logic [2:0] stat_code,
  output logic       irq
);

  localparam int BIT_W = $clog2(BYTE_BITS);

  sym_e             rx_s, tx_s;
  trk_e             trk_state;
  logic [BIT_W-1:0] bit_idx;
  logic             byte_done, trk_sym_ev, crc_chk, crc_bit_en, crc_init;
  logic             tx_err_ev, clash_ev, tdre, crc_err_ev;
  logic [7:0]       crc;
  stat_e            code;

  assign sym_ready  = 1'b1;
  assign rx_s       = sym_e'(rx_sym);
  assign tx_s       = sym_e'(tx_sym);
  assign crc_err_ev = crc_chk && (crc != CRC_RESIDUE);
  assign stat_code  = code;

  j1850_sym_tracker #(
    .BYTE_BITS  (BYTE_BITS),
    .BYTE_CNT_W (BYTE_CNT_W)
  ) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (sym_valid),
    .rx_s       (rx_s),
    .tx_active  (tx_active),
    .state      (trk_state),
    .bit_idx    (bit_idx),
    .byte_done  (byte_done),
    .sym_err_ev (trk_sym_ev),
    .crc_chk    (crc_chk),
    .crc_bit_en (crc_bit_en),
    .crc_init   (crc_init)
  );

  j1850_crc8 #(
    .CRC_W (8),
    .POLY  (CRC_POLY),
    .INIT  (CRC_INIT)
  ) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (crc_init),
    .bit_en  (crc_bit_en),
    .bit_val (rx_s == SYM_B1),
    .crc     (crc)
  );

  j1850_tx_guard #(
    .BIT_W (BIT_W)
  ) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (sym_valid),
    .tx_active  (tx_active),
    .rx_s       (rx_s),
    .tx_s       (tx_s),
    .bit_idx    (bit_idx),
    .line_idle  (trk_state == TRK_WAIT_SOF),
    .byte_done  (byte_done),
    .tx_req     (tx_req),
    .bus_active (bus_active),
    .tx_load    (tx_load),
    .tx_go      (tx_go),
    .tx_abort   (tx_abort),
    .tx_err_ev  (tx_err_ev),
    .clash_ev   (clash_ev),
    .tdre       (tdre)
  );

  j1850_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_ev  (trk_sym_ev || clash_ev),
    .tx_ev   (tx_err_ev),
    .crc_ev  (crc_err_ev),
    .tdre    (tdre),
    .stat_rd (stat_rd),
    .irq_en  (irq_en),
    .code    (code),
    .irq     (irq)
  );

  // R3: every abort leaves a transmission or symbol error behind
  a_r3_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> ((stat_code == ST_SYMERR) || (stat_code == ST_TXERR)));

  // R5: a checked frame with a bad residue reports at least a CRC error
  a_r5_crc_reported: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_ev |=> (stat_code >= ST_CRC));

endmodule

// File: tb/j1850_err_monitor_bench.sv
module j1850_err_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 44;

  typedef struct packed {
    logic       v;
    logic [2:0] rx;
    logic       ta;
    logic [2:0] ts;
    logic       req;
    logic       bact;
    logic       ld;
    logic       rd;
    logic       ie;
    logic [2:0] code;
    logic       ab;
    logic       go;
    logic       irq;
    logic [3:0] rid;
  } vec_t;

  function automatic vec_t mk(int v, int rx, int ta, int ts, int req, int bact,
                              int ld, int rd, int ie, int code, int ab, int go,
                              int irq, int rid);
    vec_t r;
    r.v = 1'(v);   r.rx = 3'(rx);   r.ta = 1'(ta);     r.ts = 3'(ts);
    r.req = 1'(req); r.bact = 1'(bact); r.ld = 1'(ld); r.rd = 1'(rd);
    r.ie = 1'(ie); r.code = 3'(code); r.ab = 1'(ab);   r.go = 1'(go);
    r.irq = 1'(irq); r.rid = 4'(rid);
    return r;
  endfunction

  // symbols: 0 BIT0, 1 BIT1, 2 SOF, 3 EOD, 4 EOF, 5 BREAK, 6 INV, 7 IDLE
  //                            v rx ta ts rq ba ld rd ie  cd ab go iq  req
  localparam vec_t VECS [NVEC] = '{
    mk(1,7,0,0,0,0,0,0,1, 0,0,0,0, 12), // R12 quiet
    mk(0,7,0,0,1,1,0,0,1, 0,0,0,0,  8), // R8 bus stuck active
    mk(0,7,0,0,1,0,0,0,1, 0,0,1,0,  8), // R8 bus released
    mk(1,7,1,2,1,0,0,0,1, 3,1,1,1,  7), // R7 SOF not echoed
    mk(0,7,0,0,1,0,0,0,1, 3,0,0,1,  7), // R7 no retry
    mk(0,7,0,0,0,0,0,0,1, 3,0,0,1,  7), // R7 command dropped
    mk(0,7,0,0,1,0,0,0,1, 3,0,1,1,  7), // R7 new command
    mk(0,7,0,0,0,0,0,1,1, 0,0,0,0, 11), // R11 read clears
    mk(1,2,0,0,0,0,0,0,1, 0,0,0,0,  4),
    mk(1,1,0,0,0,0,0,0,1, 0,0,0,0,  4),
    mk(1,6,0,0,0,0,0,0,1, 4,0,0,1,  4), // R4 invalid in frame
    mk(1,2,0,0,0,0,0,0,1, 4,0,0,1,  6), // R6 SOF ignored before idle
    mk(0,7,0,0,0,0,0,1,1, 0,0,0,0,  6),
    mk(1,0,0,0,0,0,0,0,1, 0,0,0,0,  6),
    mk(1,7,0,0,0,0,0,0,1, 0,0,0,0,  6),
    mk(1,2,0,0,0,0,0,0,1, 0,0,0,0,  1),
    mk(1,0,0,0,0,0,0,0,1, 0,0,0,0,  1),
    mk(1,1,0,0,0,0,0,0,1, 0,0,0,0,  1),
    mk(1,3,0,0,0,0,0,0,1, 4,0,0,1,  1), // R1 EOD at bit 2
    mk(0,7,0,0,0,0,0,1,1, 0,0,0,0, 11),
    mk(1,7,0,0,0,0,0,0,1, 0,0,0,0,  1),
    mk(1,2,0,0,0,0,0,0,1, 0,0,0,0,  6),
    mk(1,1,0,0,0,0,0,0,1, 0,0,0,0,  6),
    mk(1,5,0,0,0,0,0,0,0, 4,0,0,0, 12), // R6 break, R12 masked
    mk(0,7,0,0,0,0,0,1,1, 0,0,0,0,  6),
    mk(1,7,0,0,0,0,0,0,1, 0,0,0,0,  6),
    mk(1,2,1,2,1,0,0,0,1, 1,0,1,1, 10), // R10 echoed SOF
    mk(1,1,1,6,1,0,0,0,1, 3,1,0,1,  3), // R3 invalid bit sent
    mk(0,7,0,0,0,0,1,0,1, 3,0,0,1, 10),
    mk(0,7,0,0,0,0,0,1,1, 0,0,0,0, 11),
    mk(1,4,1,4,0,0,0,0,1, 4,1,0,1,  3), // R3 EOF sent off boundary
    mk(0,7,0,0,0,0,0,1,1, 3,0,0,1, 11), // R11 next level shows
    mk(0,7,0,0,0,0,0,1,1, 0,0,0,0, 11),
    mk(1,7,0,0,0,0,0,0,1, 0,0,0,0,  1),
    mk(1,2,1,2,0,0,0,0,1, 1,0,0,1, 10),
    mk(0,7,0,0,0,0,1,0,1, 0,0,0,0, 10),
    mk(1,0,1,3,0,0,0,0,1, 4,1,0,1,  2), // R2 clash during EOD
    mk(1,7,0,0,0,0,0,1,1, 0,0,0,0, 11),
    mk(1,2,0,0,0,0,0,0,1, 0,0,0,0, 13),
    mk(0,6,0,0,0,0,0,0,1, 0,0,0,0, 13), // R13 no valid, no effect
    mk(1,4,0,0,0,0,0,0,1, 0,0,0,0, 13),
    mk(1,2,0,0,0,0,0,0,1, 0,0,0,0,  9),
    mk(1,3,0,0,0,0,0,0,1, 4,0,0,1,  9), // R9 EOD with no byte
    mk(1,7,0,0,0,0,0,1,1, 0,0,0,0,  9)
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0, tx_active = 1'b0, tx_req = 1'b0, bus_active = 1'b0;
  logic       tx_load = 1'b0, stat_rd = 1'b0, irq_en = 1'b1;
  logic [2:0] rx_sym = 3'd7, tx_sym = 3'd0;
  logic       sym_ready, tx_go, tx_abort, irq;
  logic [2:0] stat_code;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] run_crc;

  always #(CLK_PERIOD/2) clk = ~clk;

  j1850_err_monitor #(.BYTE_CNT_W(3)) u_j1850_err_monitor (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .rx_sym(rx_sym), .tx_active(tx_active), .tx_sym(tx_sym), .tx_req(tx_req),
    .bus_active(bus_active), .tx_load(tx_load), .stat_rd(stat_rd), .irq_en(irq_en),
    .tx_go(tx_go), .tx_abort(tx_abort), .stat_code(stat_code), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] rx, input logic ta, input logic [2:0] ts);
    @(negedge clk);
    sym_valid = v; rx_sym = rx; tx_active = ta; tx_sym = ts;
    @(posedge clk);
    #1;
    sym_valid = 1'b0; tx_active = 1'b0; tx_load = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] b, input logic ta);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = run_crc[7] ^ b[i];
      run_crc = {run_crc[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
      step(1'b1, {2'b00, b[i]}, ta, {2'b00, b[i]});
    end
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed, input logic bad);
    logic [7:0] chkb;
    step(1'b1, 3'd2, 1'b0, 3'd0);
    run_crc = 8'hFF;
    for (int k = 0; k < n; k++) rx_byte(seed + 8'(k * 37), 1'b0);
    chkb = ~run_crc ^ {7'd0, bad};
    rx_byte(chkb, 1'b0);
    step(1'b1, 3'd3, 1'b0, 3'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R13 watchdog expired actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset code", int'(stat_code), 0);
    chk("R12", "reset irq", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      vec_t t;
      t = VECS[i];
      @(negedge clk);
      sym_valid = t.v; rx_sym = t.rx; tx_active = t.ta; tx_sym = t.ts;
      tx_req = t.req; bus_active = t.bact; tx_load = t.ld; stat_rd = t.rd; irq_en = t.ie;
      #1;
      chk($sformatf("R%0d", t.rid), $sformatf("vec %0d tx_abort", i), int'(tx_abort), int'(t.ab));
      chk($sformatf("R%0d", t.rid), $sformatf("vec %0d tx_go", i), int'(tx_go), int'(t.go));
      @(posedge clk);
      #1;
      chk($sformatf("R%0d", t.rid), $sformatf("vec %0d stat_code", i), int'(stat_code), int'(t.code));
      chk($sformatf("R%0d", t.rid), $sformatf("vec %0d irq", i), int'(irq), int'(t.irq));
    end
    sym_valid = 1'b0; tx_active = 1'b0; tx_req = 1'b0; tx_load = 1'b0;
    stat_rd = 1'b0; irq_en = 1'b1; bus_active = 1'b0;

    // R5: good frame, then corrupted check byte
    send_frame(3, 8'h01, 1'b0);
    chk("R5", "good frame code", int'(stat_code), 0);
    step(1'b1, 3'd4, 1'b0, 3'd0);
    send_frame(2, 8'h55, 1'b1);
    chk("R5", "bad crc code", int'(stat_code), 2);
    chk("R12", "bad crc irq", int'(irq), 1);
    stat_rd = 1'b1;
    step(1'b0, 3'd7, 1'b0, 3'd0);
    chk("R11", "crc cleared", int'(stat_code), 0);
    step(1'b1, 3'd4, 1'b0, 3'd0);

    // R9: eight bytes reach the counter ceiling, twenty pass it
    send_frame(7, 8'h10, 1'b0);
    chk("R9", "8-byte frame code", int'(stat_code), 0);
    step(1'b1, 3'd4, 1'b0, 3'd0);
    send_frame(19, 8'h33, 1'b0);
    chk("R9", "20-byte frame code", int'(stat_code), 0);
    step(1'b1, 3'd4, 1'b0, 3'd0);

    // R10: data-empty after echoed SOF and after each transmitted byte
    step(1'b1, 3'd2, 1'b1, 3'd2);
    chk("R10", "empty after SOF", int'(stat_code), 1);
    tx_load = 1'b1;
    step(1'b0, 3'd7, 1'b0, 3'd0);
    chk("R10", "load clears", int'(stat_code), 0);
    run_crc = 8'hFF;
    for (int i = 7; i >= 1; i--) step(1'b1, {2'b00, i[0]}, 1'b1, {2'b00, i[0]});
    chk("R10", "seven bits not empty", int'(stat_code), 0);
    step(1'b1, 3'd0, 1'b1, 3'd0);
    chk("R10", "empty after byte", int'(stat_code), 1);
    tx_load = 1'b1;
    step(1'b1, 3'd7, 1'b0, 3'd0);
    chk("R10", "second load clears", int'(stat_code), 0);

    // reset mid-fault
    step(1'b1, 3'd2, 1'b0, 3'd0);
    step(1'b1, 3'd6, 1'b0, 3'd0);
    chk("R4", "invalid before reset", int'(stat_code), 4);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11", "async reset code", int'(stat_code), 0);
    chk("R13", "ready in reset", int'(sym_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 3'd1, 1'b0, 3'd0);
    step(1'b1, 3'd3, 1'b0, 3'd0);
    chk("R1", "EOD outside frame ignored", int'(stat_code), 0);
    chk("R13", "ready after reset", int'(sym_ready), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule